// File: doc/BRIEF.md
# Dual-Mode Quasi-Bidirectional Port Controller

This block controls one 8-bit port of an 8051-style microcontroller. It can serve as general-purpose I/O or be taken over as an external memory bus. In port mode it keeps an output latch that software writes as a whole byte or one bit at a time. For every pin it produces three separate drive enables: a strong pulldown, a strong pullup and a weak pullup. A pin driven low uses the pulldown. A pin that has just gone high gets a short strong-pullup pulse. A pin held high keeps only the weak pullup, so it also works as an input.

When the core requests an external memory access, the block switches the pins to bus behaviour. The address byte is driven while the address strobe is high. After that, write data is driven, or on a read the pins are released and the incoming byte is captured. Any access to the port register returns the pins to port behaviour.

A parameter selects the open-drain variant, in which no pullup is ever enabled in port mode. A second parameter removes the latch, for parts that have no internal program memory. In that case the port stays a bus permanently.

Top module: `qport_ctrl`

## Requirements
- R1: After a synchronous reset the latch holds all ones and the port is in port mode. Every pin has its pulldown and strong pullup off. The weak pullup is on for every pin, except in the open-drain variant, where all enables are off.
- R2: A byte write (sfr_bit_mode=0) with sfr_wr loads all 8 bits of sfr_wdata into the latch. The new drive levels appear on the outputs one clock after the write cycle.
- R3: A bit write (sfr_bit_mode=1) loads sfr_wdata[0] into the latch bit indexed by sfr_bit_sel. The other seven bits keep their values.
- R4: In port mode, when a latch bit changes from 0 to 1, that pin's strong pullup is on for exactly 2 clock cycles. After that, its weak pullup is on and its strong pullup is off.
- R5: In port mode, a latch bit of 0 turns on that pin's pulldown and turns off both pullups. A pin never has its pulldown and any pullup on in the same cycle.
- R6: A port read with sfr_rmw=0 returns the sampled pin_in byte on sfr_rdata one clock later. A read with sfr_rmw=1 returns the latch value instead.
- R7: bus_req moves the port into bus mode, and it stays there until a port register access. An sfr_wr or sfr_rd returns the port to port mode, and the register access wins when both arrive in the same cycle.
- R8: In bus mode, while bus_ale is high, the port drives bus_addr with complementary drivers. For each pin, pulldown = ~bit, strong pullup = bit, and weak pullup = 0.
- R9: In bus mode with bus_ale low, the port drives bus_wdata the same way when bus_wr is high. When bus_wr is low, all enables are off and pin_in is captured into bus_rdata one clock later.
- R10: In the open-drain variant (OPEN_DRAIN=1), port mode never enables a strong or a weak pullup. A latch bit of 1 releases its pin with all enables off.
- R11: Without a latch (HAS_LATCH=0), the port is always in bus mode. Register writes have no effect on the outputs, and a read with sfr_rmw=1 returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_wr | input | 1 | Port register write strobe |
| sfr_rd | input | 1 | Port register read strobe |
| sfr_bit_mode | input | 1 | 1 = single-bit access, 0 = byte access |
| sfr_bit_sel | input | 3 | Bit index for single-bit access |
| sfr_rmw | input | 1 | Read returns the latch (1) or the pins (0) |
| sfr_wdata | input | 8 | Write data; bit 0 is used in bit mode |
| sfr_rdata | output | 8 | Registered read data |
| bus_req | input | 1 | External memory access in progress |
| bus_ale | input | 1 | Address phase strobe |
| bus_wr | input | 1 | Data phase is a write |
| bus_addr | input | 8 | Address byte for the address phase |
| bus_wdata | input | 8 | Write data for the data phase |
| bus_rdata | output | 8 | Captured read data |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Driven level per pin |
| pd_en | output | 8 | Strong pulldown enable per pin |
| spu_en | output | 8 | Strong pullup enable per pin |
| wpu_en | output | 8 | Weak pullup enable per pin |

## Verification
The bench builds three copies that share one set of inputs. The first is a quasi-bidirectional port with a latch (OPEN_DRAIN=0, HAS_LATCH=1), which exercises the strong-then-weak pullup timing. The second is an open-drain port with a latch (OPEN_DRAIN=1, HAS_LATCH=1), which shows that port-mode pullups never turn on while its bus drive stays complementary. The third is a latchless bus-only port (HAS_LATCH=0), which shows that every register write falls on a port with no latch and that the mode never leaves the bus.

// File: rtl/qport_pkg.sv
package qport_pkg;
  typedef enum logic {
    MODE_PORT = 1'b0,
    MODE_BUS  = 1'b1
  } qport_mode_e;
endpackage

// File: rtl/qport_regs.sv
module qport_regs
  import qport_pkg::*;
#(
  parameter int W         = 8,
  parameter bit HAS_LATCH = 1'b1,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sfr_wr,
  input  logic             sfr_rd,
  input  logic             sfr_bit_mode,
  input  logic [SEL_W-1:0] sfr_bit_sel,
  input  logic             sfr_rmw,
  input  logic [W-1:0]     sfr_wdata,
  input  logic             bus_req,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     latch_d,
  output logic [W-1:0]     latch_q,
  output qport_mode_e      mode_d,
  output qport_mode_e      mode_q,
  output logic [W-1:0]     sfr_rdata
);
  localparam qport_mode_e RST_MODE = HAS_LATCH ? MODE_PORT : MODE_BUS;

  always_comb begin
    latch_d = latch_q;
    if (HAS_LATCH && sfr_wr) begin
      if (sfr_bit_mode) latch_d[sfr_bit_sel] = sfr_wdata[0];
      else              latch_d = sfr_wdata;
    end
  end

  always_comb begin
    if (!HAS_LATCH)             mode_d = MODE_BUS;
    else if (sfr_wr || sfr_rd)  mode_d = MODE_PORT;
    else if (bus_req)           mode_d = MODE_BUS;
    else                        mode_d = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '1;
      mode_q    <= RST_MODE;
      sfr_rdata <= '0;
    end else begin
      latch_q <= latch_d;
      mode_q  <= mode_d;
      if (sfr_rd) sfr_rdata <= sfr_rmw ? latch_q : pin_in;
    end
  end
endmodule

// File: rtl/qport_pullup_timer.sv
module qport_pullup_timer #(
  parameter int W   = 8,
  parameter int CYC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] latch_d,
  input  logic [W-1:0] latch_q,
  output logic [W-1:0] strong_d
);
  localparam int CW = (CYC < 1) ? 1 : $clog2(CYC + 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      if (latch_d[i] && !latch_q[i]) cnt_d = CW'(CYC);
      else if (cnt_q != '0)          cnt_d = cnt_q - 1'b1;
      else                           cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
    end

    assign strong_d[i] = (cnt_d != '0);
  end
endmodule

// File: rtl/qport_drive.sv
module qport_drive
  import qport_pkg::*;
#(
  parameter int W          = 8,
  parameter bit OPEN_DRAIN = 1'b0,
  parameter bit HAS_LATCH  = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  qport_mode_e  mode_d,
  input  logic [W-1:0] latch_d,
  input  logic [W-1:0] strong_d,
  input  logic         bus_req,
  input  logic         bus_ale,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] spu_en,
  output logic [W-1:0] wpu_en,
  output logic [W-1:0] bus_rdata
);
  localparam logic [W-1:0] RST_PIN = HAS_LATCH ? '1 : '0;
  localparam logic [W-1:0] RST_WPU = (HAS_LATCH && !OPEN_DRAIN) ? '1 : '0;

  logic [W-1:0] pin_n, pd_n, spu_n, wpu_n, bus_val;
  logic         bus_drive, bus_capture;

  always_comb begin
    bus_drive   = 1'b0;
    bus_val     = '0;
    bus_capture = 1'b0;
    if (bus_ale) begin
      bus_drive = 1'b1;
      bus_val   = bus_addr;
    end else if (bus_req && bus_wr) begin
      bus_drive = 1'b1;
      bus_val   = bus_wdata;
    end else if (bus_req) begin
      bus_capture = 1'b1;
    end
  end

  always_comb begin
    if (mode_d == MODE_BUS) begin
      pin_n = bus_drive ? bus_val  : '0;
      pd_n  = bus_drive ? ~bus_val : '0;
      spu_n = bus_drive ? bus_val  : '0;
      wpu_n = '0;
    end else begin
      pin_n = latch_d;
      pd_n  = ~latch_d;
      if (OPEN_DRAIN) begin
        spu_n = '0;
        wpu_n = '0;
      end else begin
        spu_n = latch_d & strong_d;
        wpu_n = latch_d & ~strong_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out   <= RST_PIN;
      pd_en     <= '0;
      spu_en    <= '0;
      wpu_en    <= RST_WPU;
      bus_rdata <= '0;
    end else begin
      pin_out <= pin_n;
      pd_en   <= pd_n;
      spu_en  <= spu_n;
      wpu_en  <= wpu_n;
      if (mode_d == MODE_BUS && bus_capture) bus_rdata <= pin_in;
    end
  end
endmodule

// File: rtl/qport_ctrl.sv
module qport_ctrl
  import qport_pkg::*;
#(
  parameter int W             = 8,
  parameter bit OPEN_DRAIN    = 1'b0,
  parameter bit HAS_LATCH     = 1'b1,
  parameter int STRONG_CYCLES = 2,
  localparam int SEL_W        = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sfr_wr,
  input  logic             sfr_rd,
  input  logic             sfr_bit_mode,
  input  logic [SEL_W-1:0] sfr_bit_sel,
  input  logic             sfr_rmw,
  input  logic [W-1:0]     sfr_wdata,
  output logic [W-1:0]     sfr_rdata,
  input  logic             bus_req,
  input  logic             bus_ale,
  input  logic             bus_wr,
  input  logic [W-1:0]     bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pd_en,
  output logic [W-1:0]     spu_en,
  output logic [W-1:0]     wpu_en
);
  logic [W-1:0] latch_d, latch_q, strong_d;
  qport_mode_e  mode_d, mode_q;

  qport_regs #(.W(W), .HAS_LATCH(HAS_LATCH), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_bit_mode(sfr_bit_mode), .sfr_bit_sel(sfr_bit_sel), .sfr_rmw(sfr_rmw),
    .sfr_wdata(sfr_wdata), .bus_req(bus_req), .pin_in(pin_in),
    .latch_d(latch_d), .latch_q(latch_q), .mode_d(mode_d), .mode_q(mode_q),
    .sfr_rdata(sfr_rdata)
  );

  qport_pullup_timer #(.W(W), .CYC(STRONG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .latch_d(latch_d), .latch_q(latch_q),
    .strong_d(strong_d)
  );

  qport_drive #(.W(W), .OPEN_DRAIN(OPEN_DRAIN), .HAS_LATCH(HAS_LATCH)) u_drive (
    .clk(clk), .rst(rst), .mode_d(mode_d), .latch_d(latch_d),
    .strong_d(strong_d), .bus_req(bus_req), .bus_ale(bus_ale), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_in(pin_in),
    .pin_out(pin_out), .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/qport_ctrl_chk.sv
module qport_ctrl_chk
  import qport_pkg::*;
#(
  parameter int W          = 8,
  parameter bit OPEN_DRAIN = 1'b0,
  parameter bit HAS_LATCH  = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        sfr_wr,
  input logic        sfr_rd,
  input logic        sfr_rmw,
  input logic [W-1:0] sfr_rdata,
  input logic        bus_req,
  input logic        bus_ale,
  input logic        bus_wr,
  input logic [W-1:0] pd_en,
  input logic [W-1:0] spu_en,
  input logic [W-1:0] wpu_en,
  input logic [W-1:0] latch_q,
  input qport_mode_e mode_q
);
  // R5
  no_drive_fight_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_en & (spu_en | wpu_en)) == '0);

  // R10
  od_no_pullup_chk: assert property (@(posedge clk) disable iff (rst)
    (OPEN_DRAIN && mode_q == MODE_PORT) |-> ((spu_en | wpu_en) == '0));

  // R7
  sfr_returns_port_chk: assert property (@(posedge clk) disable iff (rst)
    (HAS_LATCH && (sfr_wr || sfr_rd)) |=> (mode_q == MODE_PORT));

  // R6
  rmw_read_chk: assert property (@(posedge clk) disable iff (rst)
    (HAS_LATCH && sfr_rd && sfr_rmw) |=> (sfr_rdata == $past(latch_q)));

  // R11
  no_latch_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!HAS_LATCH && sfr_rd && sfr_rmw) |=> (sfr_rdata == '1));

  // R9
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BUS && bus_req && !bus_ale && !bus_wr && !sfr_wr && !sfr_rd)
      |=> ((pd_en | spu_en | wpu_en) == '0));

  for (genvar i = 0; i < W; i++) begin : g_bit
    // R4
    strong_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(spu_en[i]) && mode_q == MODE_PORT && !sfr_wr && !bus_req)
        |=> spu_en[i]);
  end
endmodule

bind qport_ctrl qport_ctrl_chk #(.W(W), .OPEN_DRAIN(OPEN_DRAIN), .HAS_LATCH(HAS_LATCH)) u_chk (
  .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rmw(sfr_rmw),
  .sfr_rdata(sfr_rdata), .bus_req(bus_req), .bus_ale(bus_ale), .bus_wr(bus_wr),
  .pd_en(pd_en), .spu_en(spu_en), .wpu_en(wpu_en), .latch_q(latch_q),
  .mode_q(mode_q)
);

// File: tb/qport_ctrl_bench.sv
`timescale 1ns/1ps
module qport_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, sfr_wr, sfr_rd, sfr_bit_mode, sfr_rmw;
  logic [2:0] sfr_bit_sel;
  logic [7:0] sfr_wdata, bus_addr, bus_wdata, pin_in;
  logic       bus_req, bus_ale, bus_wr;

  logic [7:0] a_rd, a_brd, a_pin, a_pd, a_spu, a_wpu;
  logic [7:0] o_rd, o_brd, o_pin, o_pd, o_spu, o_wpu;
  logic [7:0] n_rd, n_brd, n_pin, n_pd, n_spu, n_wpu;

  qport_ctrl #(.OPEN_DRAIN(1'b0), .HAS_LATCH(1'b1)) u_qport_ctrl (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_bit_mode(sfr_bit_mode), .sfr_bit_sel(sfr_bit_sel), .sfr_rmw(sfr_rmw),
    .sfr_wdata(sfr_wdata), .sfr_rdata(a_rd), .bus_req(bus_req), .bus_ale(bus_ale),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(a_brd),
    .pin_in(pin_in), .pin_out(a_pin), .pd_en(a_pd), .spu_en(a_spu), .wpu_en(a_wpu));

  qport_ctrl #(.OPEN_DRAIN(1'b1), .HAS_LATCH(1'b1)) u_qport_ctrl_od (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_bit_mode(sfr_bit_mode), .sfr_bit_sel(sfr_bit_sel), .sfr_rmw(sfr_rmw),
    .sfr_wdata(sfr_wdata), .sfr_rdata(o_rd), .bus_req(bus_req), .bus_ale(bus_ale),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(o_brd),
    .pin_in(pin_in), .pin_out(o_pin), .pd_en(o_pd), .spu_en(o_spu), .wpu_en(o_wpu));

  qport_ctrl #(.OPEN_DRAIN(1'b1), .HAS_LATCH(1'b0)) u_qport_ctrl_nl (
    .clk(clk), .rst(rst), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_bit_mode(sfr_bit_mode), .sfr_bit_sel(sfr_bit_sel), .sfr_rmw(sfr_rmw),
    .sfr_wdata(sfr_wdata), .sfr_rdata(n_rd), .bus_req(bus_req), .bus_ale(bus_ale),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(n_brd),
    .pin_in(pin_in), .pin_out(n_pin), .pd_en(n_pd), .spu_en(n_spu), .wpu_en(n_wpu));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    sfr_wr = 0; sfr_rd = 0; sfr_bit_mode = 0; sfr_bit_sel = 0; sfr_rmw = 0;
    sfr_wdata = 0; bus_req = 0; bus_ale = 0; bus_wr = 0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    idle(); sfr_wr = 1; sfr_wdata = d; tick(); idle();
  endtask

  // {bit_mode, sel[2:0], wdata[7:0], expected latch[7:0]}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd3, 8'h01, 8'h08},
    {1'b0, 3'd0, 8'hA5, 8'hA5},
    {1'b1, 3'd0, 8'hFE, 8'hA4},
    {1'b1, 3'd7, 8'h00, 8'h24},
    {1'b0, 3'd0, 8'h5A, 8'h5A},
    {1'b1, 3'd6, 8'h00, 8'h1A},
    {1'b0, 3'd0, 8'hFF, 8'hFF}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); pin_in = 8'h00; bus_addr = 0; bus_wdata = 0;
    rst = 1;
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    chk("R1 pd", a_pd, 8'h00);
    chk("R1 spu", a_spu, 8'h00);
    chk("R1 wpu", a_wpu, 8'hFF);
    chk("R1 od wpu", o_wpu, 8'h00);
    chk("R1 od pd", o_pd, 8'h00);

    // R2 R3 R5 R10 R11 vector walk
    foreach (VEC[k]) begin
      idle();
      sfr_wr = 1; sfr_bit_mode = VEC[k][19]; sfr_bit_sel = VEC[k][18:16];
      sfr_wdata = VEC[k][15:8];
      tick();
      idle();
      chk(VEC[k][19] ? "R3 bit write pd" : "R2 byte write pd", a_pd, ~VEC[k][7:0]);
      chk("R5 no pullup on low", (a_spu | a_wpu) & ~VEC[k][7:0], 8'h00);
      chk("R10 od pd", o_pd, ~VEC[k][7:0]);
      chk("R10 od pullups", o_spu | o_wpu, 8'h00);
      chk("R11 no latch pd", n_pd | n_spu | n_wpu, 8'h00);
    end
    repeat (3) tick();

    // R4 strong pullup pulse
    wr_byte(8'h00);
    wr_byte(8'h01);
    chk("R4 strong c1", a_spu, 8'h01);
    chk("R4 weak off c1", a_wpu, 8'h00);
    tick();
    chk("R4 strong c2", a_spu, 8'h01);
    tick();
    chk("R4 strong ended", a_spu, 8'h00);
    chk("R4 weak hold", a_wpu, 8'h01);
    idle(); sfr_wr = 1; sfr_bit_mode = 1; sfr_bit_sel = 3'd5; sfr_wdata = 8'h01;
    tick(); idle();
    chk("R4 R3 bit strong", a_spu, 8'h20);
    chk("R4 other weak", a_wpu, 8'h01);
    repeat (3) tick();

    // R6 reads
    pin_in = 8'h3C;
    sfr_rd = 1; sfr_rmw = 0; tick(); idle();
    chk("R6 pin read", a_rd, 8'h3C);
    sfr_rd = 1; sfr_rmw = 1; tick(); idle();
    chk("R6 rmw read", a_rd, 8'h21);
    chk("R11 rmw read all ones", n_rd, 8'hFF);

    // R8 address phase
    bus_req = 1; bus_ale = 1; bus_addr = 8'h96; tick();
    chk("R8 addr pin", a_pin, 8'h96);
    chk("R8 addr pd", a_pd, 8'h69);
    chk("R8 addr spu", a_spu, 8'h96);
    chk("R8 addr wpu", a_wpu, 8'h00);
    chk("R8 od addr spu", o_spu, 8'h96);
    chk("R11 nl addr pin", n_pin, 8'h96);
    // R9 write data
    bus_ale = 0; bus_wr = 1; bus_wdata = 8'h3A; tick();
    chk("R9 wdata pin", a_pin, 8'h3A);
    chk("R9 wdata pd", a_pd, 8'hC5);
    // R9 read data
    bus_wr = 0; pin_in = 8'hE7; tick();
    chk("R9 release", a_pd | a_spu | a_wpu, 8'h00);
    chk("R9 capture", a_brd, 8'hE7);
    // R7 stays in bus mode
    idle(); tick();
    chk("R7 bus sticky", a_pd | a_wpu, 8'h00);
    sfr_rd = 1; tick(); idle();
    chk("R7 back to port pd", a_pd, 8'hDE);
    chk("R7 back to port wpu", a_wpu, 8'h21);
    // R7 register access wins over bus_req
    bus_req = 1; sfr_wr = 1; sfr_wdata = 8'h0F; tick(); idle();
    chk("R7 sfr wins", a_pd, 8'hF0);
    chk("R11 write ignored", n_pd | n_spu | n_wpu, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule